// File: doc/BRIEF.md
# SIMT Divergence Mask Controller

This block holds the lane-enable mask of a single warp while the warp steps through two-way branches. When a branch splits the currently active lanes, it saves the mask from before the branch on a small stack. It then runs the lanes whose condition bit is set. When the sequencer signals the end of that path, it switches to the remaining lanes. At the next path end it restores the saved mask, which marks reconvergence. A branch on which every active lane agrees does not split the warp and costs no extra path.

Every issued instruction takes exactly one issue slot, however many lanes are live. The block keeps two saturating tallies: issue slots used, and active lanes summed over those slots. Lane efficiency is the lane tally divided by the lane count times the slot tally. Nesting is limited to the stack depth. A split branch that arrives with the stack full is refused and sets a sticky error flag.

Top module: `simt_div_ctrl`

## Requirements
- R1: After reset, the mask is all ones, depth is 0, path is 0 (no pending split), both tallies are 0 and the error flag is low.
- R2: A branch whose condition splits the active lanes loads the mask with `mask & cond_i`, where bit i is lane i and a 1 means taken. It also raises the depth by one and sets the path to 1 (taken side).
- R3: A branch on which all active lanes agree, whether all set or all clear, leaves the mask and the depth unchanged.
- R4: The first path end after a split loads the mask with the pre-branch mask AND NOT the condition, and sets the path to 2 (other side).
- R5: The second path end after a split restores the exact pre-branch mask and lowers the depth by one; the path returns to 0 at depth 0.
- R6: Each cycle with `issue_i` high adds one to the slot tally and adds the popcount of the mask in force that cycle to the lane tally, even when few lanes are live.
- R7: Splits nest up to DEPTH levels, and each reconvergence restores the mask of the enclosing level.
- R8: A split branch with the stack full leaves the mask and the depth unchanged and sets the error flag, which stays high until reset.
- R9: A path end with an empty stack has no effect on the mask, depth or path.
- R10: Both tallies stop at their all-ones value instead of wrapping.
- R11: When a branch and a path end arrive in the same cycle, the branch is acted on and the path end is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | An instruction issues this cycle under the current mask |
| branch_i | input | 1 | A two-way branch is evaluated this cycle |
| cond_i | input | LANES | Per-lane branch condition, 1 = taken |
| path_end_i | input | 1 | The current branch side has finished |
| active_mask_o | output | LANES | Lanes enabled for the current instruction |
| path_o | output | 2 | 0 none pending, 1 taken side, 2 other side |
| depth_o | output | $clog2(DEPTH+1) | Number of saved masks |
| overflow_o | output | 1 | Sticky stack-overflow flag |
| issue_cnt_o | output | ISSUE_W | Saturating issue-slot tally |
| lane_cnt_o | output | LANE_W | Saturating active-lane tally |

## Verification
The assertions check on every cycle that the mask is never empty and that the stack stays within bounds. They also check that the taken mask is a subset of the condition, that the other side is disjoint from the taken side, that the error flag is sticky, and that the tallies never decrease. Restoration of the exact pre-branch mask after nested splits, the precise tally totals, saturation values and the branch-over-path-end priority can only be shown by the bench's directed scenarios against precomputed masks.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;
  typedef enum logic [1:0] {
    PATH_NONE  = 2'd0,
    PATH_TAKEN = 2'd1,
    PATH_OTHER = 2'd2
  } path_e;

  localparam int unsigned DEF_LANES = 32;
  localparam int unsigned DEF_DEPTH = 4;
endpackage

// File: rtl/simt_mask_stack.sv
module simt_mask_stack #(
  parameter int unsigned LANES = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             flip_i,
  input  logic [LANES-1:0] saved_i,
  input  logic [LANES-1:0] other_i,
  output logic [LANES-1:0] top_saved_o,
  output logic [LANES-1:0] top_other_o,
  output logic             top_else_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [LANES-1:0] saved_q [DEPTH];
  logic [LANES-1:0] other_q [DEPTH];
  logic [DEPTH-1:0] else_q;
  logic [IDX_W-1:0] top_idx;

  assign top_idx = IDX_W'(cnt_q - CNT_W'(1));
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (push_i && !full_o) cnt_q <= cnt_q + CNT_W'(1);
    else if (pop_i && !empty_o) cnt_q <= cnt_q - CNT_W'(1);
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        saved_q[g] <= '0;
        other_q[g] <= '0;
        else_q[g]  <= 1'b0;
      end else if (push_i && !full_o && cnt_q == CNT_W'(g)) begin
        saved_q[g] <= saved_i;
        other_q[g] <= other_i;
        else_q[g]  <= 1'b0;
      end else if (flip_i && !empty_o && top_idx == IDX_W'(g)) begin
        else_q[g]  <= 1'b1;
      end
    end
  end

  assign top_saved_o = empty_o ? '0 : saved_q[top_idx];
  assign top_other_o = empty_o ? '0 : other_q[top_idx];
  assign top_else_o  = empty_o ? 1'b0 : else_q[top_idx];

  a_r8_no_push_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  a_r9_no_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i || flip_i) |-> !empty_o);
  a_r7_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(DEPTH));
  a_r5_pop_lowers: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> cnt_q == $past(cnt_q) - CNT_W'(1));
endmodule

// File: rtl/simt_issue_stats.sv
module simt_issue_stats #(
  parameter int unsigned LANES   = 32,
  parameter int unsigned ISSUE_W = 32,
  parameter int unsigned LANE_W  = 40,
  localparam int unsigned PC_W   = $clog2(LANES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               issue_i,
  input  logic [LANES-1:0]   mask_i,
  output logic [ISSUE_W-1:0] issue_cnt_o,
  output logic [LANE_W-1:0]  lane_cnt_o
);
  localparam logic [ISSUE_W-1:0] ISSUE_MAX = '1;
  localparam logic [LANE_W-1:0]  LANE_MAX  = '1;

  logic [PC_W-1:0]    pop_cnt;
  logic [LANE_W:0]    lane_sum;
  logic [ISSUE_W-1:0] issue_q;
  logic [LANE_W-1:0]  lane_q;

  always_comb begin
    pop_cnt = '0;
    for (int i = 0; i < LANES; i++) pop_cnt = pop_cnt + PC_W'(mask_i[i]);
  end

  assign lane_sum = {1'b0, lane_q} + (LANE_W + 1)'(pop_cnt);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_q <= '0;
      lane_q  <= '0;
    end else if (issue_i) begin
      if (issue_q != ISSUE_MAX) issue_q <= issue_q + ISSUE_W'(1);
      lane_q <= lane_sum[LANE_W] ? LANE_MAX : lane_sum[LANE_W-1:0];
    end
  end

  assign issue_cnt_o = issue_q;
  assign lane_cnt_o  = lane_q;

  a_r10_issue_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> issue_q >= $past(issue_q));
  a_r10_lane_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> lane_q >= $past(lane_q));
  a_r6_one_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && issue_q != ISSUE_MAX) |=> issue_q == $past(issue_q) + ISSUE_W'(1));
  a_r6_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_i |=> $stable(issue_q) && $stable(lane_q));
endmodule

// File: rtl/simt_div_ctrl.sv
module simt_div_ctrl
  import simt_div_pkg::*;
#(
  parameter int unsigned LANES   = DEF_LANES,
  parameter int unsigned DEPTH   = DEF_DEPTH,
  parameter int unsigned ISSUE_W = 32,
  parameter int unsigned LANE_W  = 40,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               issue_i,
  input  logic               branch_i,
  input  logic [LANES-1:0]   cond_i,
  input  logic               path_end_i,
  output logic [LANES-1:0]   active_mask_o,
  output logic [1:0]         path_o,
  output logic [CNT_W-1:0]   depth_o,
  output logic               overflow_o,
  output logic [ISSUE_W-1:0] issue_cnt_o,
  output logic [LANE_W-1:0]  lane_cnt_o
);
  logic [LANES-1:0] mask_q, mask_d;
  logic [LANES-1:0] taken_lanes, other_lanes;
  logic             split;
  logic             err_q;
  logic             push, pop, flip;
  logic [LANES-1:0] top_saved, top_other;
  logic             top_else, stk_full, stk_empty;
  path_e            path;

  assign taken_lanes = mask_q & cond_i;
  assign other_lanes = mask_q & ~cond_i;
  assign split       = (|taken_lanes) && (|other_lanes);

  always_comb begin
    mask_d = mask_q;
    push   = 1'b0;
    pop    = 1'b0;
    flip   = 1'b0;
    if (branch_i) begin
      if (split && !stk_full) begin
        push   = 1'b1;
        mask_d = taken_lanes;
      end
    end else if (path_end_i && !stk_empty) begin
      if (!top_else) begin
        flip   = 1'b1;
        mask_d = top_other;
      end else begin
        pop    = 1'b1;
        mask_d = top_saved;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      err_q  <= 1'b0;
    end else begin
      mask_q <= mask_d;
      if (branch_i && split && stk_full) err_q <= 1'b1;
    end
  end

  simt_mask_stack #(.LANES(LANES), .DEPTH(DEPTH)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .flip_i      (flip),
    .saved_i     (mask_q),
    .other_i     (other_lanes),
    .top_saved_o (top_saved),
    .top_other_o (top_other),
    .top_else_o  (top_else),
    .count_o     (depth_o),
    .full_o      (stk_full),
    .empty_o     (stk_empty)
  );

  simt_issue_stats #(.LANES(LANES), .ISSUE_W(ISSUE_W), .LANE_W(LANE_W)) u_stats (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .issue_i     (issue_i),
    .mask_i      (mask_q),
    .issue_cnt_o (issue_cnt_o),
    .lane_cnt_o  (lane_cnt_o)
  );

  always_comb begin
    if (stk_empty)     path = PATH_NONE;
    else if (top_else) path = PATH_OTHER;
    else               path = PATH_TAKEN;
  end

  assign path_o        = path;
  assign active_mask_o = mask_q;
  assign overflow_o    = err_q;

  a_r2_mask_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q != '0);
  a_r2_taken_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_i && split && !stk_full) |=> ((mask_q & ~$past(cond_i)) == '0));
  a_r3_uniform_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (branch_i && !split) |=> $stable(mask_q) && $stable(depth_o));
  a_r4_disjoint_sides: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!branch_i && path_end_i && !stk_empty && !top_else)
      |=> ((mask_q & $past(mask_q)) == '0));
  a_r8_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |=> err_q);
  a_r9_empty_end_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!branch_i && path_end_i && stk_empty) |=> $stable(mask_q) && depth_o == '0);
endmodule

// File: tb/simt_div_ctrl_test.sv
`timescale 1ns/1ps
module simt_div_ctrl_test;
  localparam int LANES = 32;
  localparam int DEPTH = 4;
  localparam int ISSUE_W = 6;
  localparam int LANE_W = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic issue_i = 1'b0, branch_i = 1'b0, path_end_i = 1'b0;
  logic [LANES-1:0] cond_i = '0;
  logic [LANES-1:0] active_mask_o;
  logic [1:0] path_o;
  logic [2:0] depth_o;
  logic overflow_o;
  logic [ISSUE_W-1:0] issue_cnt_o;
  logic [LANE_W-1:0] lane_cnt_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  simt_div_ctrl #(.LANES(LANES), .DEPTH(DEPTH), .ISSUE_W(ISSUE_W), .LANE_W(LANE_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .issue_i(issue_i), .branch_i(branch_i),
    .cond_i(cond_i), .path_end_i(path_end_i), .active_mask_o(active_mask_o),
    .path_o(path_o), .depth_o(depth_o), .overflow_o(overflow_o),
    .issue_cnt_o(issue_cnt_o), .lane_cnt_o(lane_cnt_o)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    issue_i = 0; branch_i = 0; path_end_i = 0; cond_i = '0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic op(input logic iss, input logic br, input logic pe, input logic [31:0] c);
    issue_i = iss; branch_i = br; path_end_i = pe; cond_i = c;
    @(negedge clk);
    issue_i = 0; branch_i = 0; path_end_i = 0; cond_i = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "mask", active_mask_o, 32'hFFFF_FFFF);
    chk("R1", "depth", depth_o, 0);
    chk("R1", "path", path_o, 0);
    chk("R1", "issue", issue_cnt_o, 0);
    chk("R1", "lanes", lane_cnt_o, 0);
    chk("R1", "err", overflow_o, 0);
  endtask

  task automatic t_uniform();
    do_reset();
    op(0, 1, 0, 32'hFFFF_FFFF);
    chk("R3", "mask all-taken", active_mask_o, 32'hFFFF_FFFF);
    chk("R3", "depth all-taken", depth_o, 0);
    op(0, 1, 0, 32'h0);
    chk("R3", "mask none-taken", active_mask_o, 32'hFFFF_FFFF);
    chk("R3", "depth none-taken", depth_o, 0);
  endtask

  task automatic t_split();
    do_reset();
    op(0, 1, 0, 32'h0000_FFFF);
    chk("R2", "mask", active_mask_o, 32'h0000_FFFF);
    chk("R2", "depth", depth_o, 1);
    chk("R2", "path", path_o, 1);
    op(1, 0, 0, 0);
    op(0, 0, 1, 0);
    chk("R4", "mask", active_mask_o, 32'hFFFF_0000);
    chk("R4", "path", path_o, 2);
    op(1, 0, 0, 0);
    op(0, 0, 1, 0);
    chk("R5", "mask", active_mask_o, 32'hFFFF_FFFF);
    chk("R5", "depth", depth_o, 0);
    chk("R5", "path", path_o, 0);
    op(1, 0, 0, 0);
    chk("R6", "issue slots", issue_cnt_o, 3);
    chk("R6", "lane sum", lane_cnt_o, 64);
  endtask

  task automatic t_nest();
    do_reset();
    op(0, 1, 0, 32'h00FF_00FF);
    op(0, 1, 0, 32'h0000_FFFF);
    chk("R7", "inner mask", active_mask_o, 32'h0000_00FF);
    chk("R7", "depth", depth_o, 2);
    op(0, 1, 0, 32'hFFFF_FFFF);
    chk("R3", "inner uniform", active_mask_o, 32'h0000_00FF);
    op(0, 0, 1, 0);
    chk("R7", "inner other", active_mask_o, 32'h00FF_0000);
    op(0, 0, 1, 0);
    chk("R7", "outer restored", active_mask_o, 32'h00FF_00FF);
    chk("R7", "depth back", depth_o, 1);
    op(0, 0, 1, 0);
    chk("R7", "outer other", active_mask_o, 32'hFF00_FF00);
  endtask

  task automatic t_overflow();
    do_reset();
    op(0, 1, 0, 32'h0000_FFFF);
    op(0, 1, 0, 32'h0000_00FF);
    op(0, 1, 0, 32'h0000_000F);
    op(0, 1, 0, 32'h0000_0003);
    chk("R7", "depth full", depth_o, 4);
    chk("R8", "no err yet", overflow_o, 0);
    op(0, 1, 0, 32'h0000_0001);
    chk("R8", "err", overflow_o, 1);
    chk("R8", "mask held", active_mask_o, 32'h0000_0003);
    chk("R8", "depth held", depth_o, 4);
    op(0, 0, 1, 0);
    op(0, 0, 1, 0);
    chk("R8", "err sticky", overflow_o, 1);
    chk("R5", "mask after pop", active_mask_o, 32'h0000_000F);
  endtask

  task automatic t_empty_end();
    do_reset();
    op(0, 0, 1, 0);
    chk("R9", "mask", active_mask_o, 32'hFFFF_FFFF);
    chk("R9", "depth", depth_o, 0);
    chk("R9", "path", path_o, 0);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 70; i++) op(1, 0, 0, 0);
    chk("R10", "issue sat", issue_cnt_o, 63);
    chk("R10", "lane sat", lane_cnt_o, 1023);
  endtask

  task automatic t_priority();
    do_reset();
    op(0, 1, 0, 32'h0000_FFFF);
    op(0, 1, 1, 32'h0000_0001);
    chk("R11", "mask", active_mask_o, 32'h0000_0001);
    chk("R11", "depth", depth_o, 2);
    chk("R11", "path", path_o, 1);
  endtask

  initial begin
    t_reset();
    t_uniform();
    t_split();
    t_nest();
    t_overflow();
    t_empty_end();
    t_saturate();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule